// File: doc/BRIEF.md
# DMA Error Status Capture

This block records the first failure reported on a host bridge's DMA path. It keeps a 64-bit status word and an address register beside it. An upstream detector issues a one-cycle error event. The event carries a kind (DMA read, DMA write or address translation), the byte lanes of the failing transfer, the doubleword offset within a 64-byte line, a block-transfer flag, an ECC syndrome and the physical address. The first event sets a primary flag and latches all of these details. Later events only mark a secondary flag until software clears the primary flags.

Software reads the two words through a small register port. It acknowledges errors by writing ones to the flag bits. While any primary flag is set and the enable input is high, an interrupt line is asserted.

A parameter selects the correctable-error variant. That variant also keeps the ECC syndrome, and it does not track translation errors.

Top module: `dma_err_capture`

## Requirements
- R1: After reset the status word and the address register read as zero, and `irq_o` is low.
- R2: An accepted event arriving while no primary flag is set sets one primary flag. The flag is at bit 62 for kind 0 (read), bit 61 for kind 1 (write) and bit 56 for kind 2 (translation). The same event latches the byte mask into status bits 47:32, the offset into bits 31:29, the block flag into bit 23 and the address into the address register. The result is readable from the cycle after the event's clock edge.
- R3: An accepted event arriving while a primary flag is set only sets the secondary flag of its kind: bit 59 for read, bit 58 for write, bit 57 for translation. All captured details and the address stay unchanged.
- R4: Writing status (select 0) with a 1 in a flag bit clears that flag, and a 0 leaves it unchanged. Detail fields of the status word and the whole address register ignore writes.
- R5: `irq_o` is high exactly when at least one primary flag is set and `irq_en_i` is high. It follows `irq_en_i` within the same cycle.
- R6: An event may arrive in the same cycle as a flag-clearing write that leaves no primary flag set. In that case the event wins: it is recorded as primary and its details are captured.
- R7: When `CORRECTABLE` is 1, the event syndrome is captured into status bits 55:48 together with the other details. Translation events (kind 2) are ignored, and bits 56 and 57 read zero.
- R8: `reg_sel_i` 0 reads the status word and 1 reads the address register, zero-extended to 64 bits. The read data is combinational from the stored state.
- R9: After all primary flags are cleared, the last captured details and the address remain readable until the next primary capture replaces them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_valid_i | input | 1 | One-cycle error event strobe |
| evt_kind_i | input | 2 | Error kind: 0 read, 1 write, 2 translation |
| evt_bmask_i | input | 16 | Byte mask of the failing transfer |
| evt_dwoff_i | input | 3 | Doubleword offset (address bits 5:3) |
| evt_block_i | input | 1 | Failing transfer was a block operation |
| evt_synd_i | input | 8 | ECC syndrome (used in the correctable variant) |
| evt_addr_i | input | ADDR_W | Physical address of the failing access |
| reg_sel_i | input | 1 | Register select: 0 status, 1 address |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 64 | Write data (ones clear flags) |
| reg_rdata_o | output | 64 | Read data of the selected register |
| irq_en_i | input | 1 | Error interrupt enable |
| irq_o | output | 1 | Error interrupt |

## Verification
Most faults in this block show up as details that change after capture. A wrong first-versus-later decision lets a second error overwrite the byte mask, offset or address, and the next status read shows the wrong values. A flag that is set in the wrong half of the word, or that does not clear, shows up on the first read after the event or write. It also shows on `irq_o` in the same cycle. The same-cycle clear-and-event race and the ignored translation kind in the correctable variant are exercised directly. Both would leave a flag word that differs from the expected one on the read that follows.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

   localparam int STAT_W  = 64;
   localparam int KINDS   = 3;
   localparam int BMASK_W = 16;
   localparam int DWOFF_W = 3;
   localparam int SYND_W  = 8;

   typedef enum logic [1:0] {
      ERR_RD = 2'd0,
      ERR_WR = 2'd1,
      ERR_XL = 2'd2
   } err_kind_e;

   // flag positions, index 0 read, 1 write, 2 translation
   localparam int PRIM_POS [KINDS] = '{62, 61, 56};
   localparam int SEC_POS  [KINDS] = '{59, 58, 57};
   localparam int BMASK_LO = 32;
   localparam int SYND_LO  = 48;
   localparam int DWOFF_LO = 29;
   localparam int BLOCK_POS = 23;

   function automatic logic [KINDS-1:0] kind_onehot(input logic [1:0] k);
      logic [KINDS-1:0] v;
      v = '0;
      for (int i = 0; i < KINDS; i++)
         if (k == 2'(i)) v[i] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/errcap_flags.sv
module errcap_flags
   import errcap_pkg::*;
#(
   parameter int N = KINDS
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] ev_set_i,
   input  logic [N-1:0] clr_prim_i,
   input  logic [N-1:0] clr_sec_i,
   output logic [N-1:0] prim_o,
   output logic [N-1:0] sec_o,
   output logic         capture_o
);

   logic [N-1:0] prim_keep;
   logic         room;

   // flags that survive this cycle's clear decide first versus later
   assign prim_keep = prim_o & ~clr_prim_i;
   assign room      = ~|prim_keep;
   assign capture_o = room & (|ev_set_i);

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic p_r, s_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            p_r <= 1'b0;
            s_r <= 1'b0;
         end else begin
            p_r <= prim_keep[i] | (room & ev_set_i[i]);
            s_r <= (s_r & ~clr_sec_i[i]) | (~room & ev_set_i[i]);
         end
      end
      assign prim_o[i] = p_r;
      assign sec_o[i]  = s_r;

      assert_w1c_prim_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_prim_i[i] && !ev_set_i[i]) |=> !prim_o[i]);
      assert_w1c_sec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_sec_i[i] && !ev_set_i[i]) |=> !sec_o[i]);
   end

   assert_first_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|ev_set_i) && prim_o == '0) |=> $countones(prim_o) == 1);
   assert_later_sec_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|ev_set_i) && (|(prim_o & ~clr_prim_i))) |=> prim_o == $past(prim_o & ~clr_prim_i));
   assert_race_event_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|ev_set_i) && (|clr_prim_i) && ((prim_o & ~clr_prim_i) == '0)) |=> (|prim_o));

endmodule

// File: rtl/errcap_detail.sv
module errcap_detail
   import errcap_pkg::*;
#(
   parameter int ADDR_W  = 34,
   parameter bit SYND_EN = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               load_i,
   input  logic [BMASK_W-1:0] bmask_i,
   input  logic [DWOFF_W-1:0] dwoff_i,
   input  logic               block_i,
   input  logic [SYND_W-1:0]  synd_i,
   input  logic [ADDR_W-1:0]  addr_i,
   output logic [BMASK_W-1:0] bmask_o,
   output logic [DWOFF_W-1:0] dwoff_o,
   output logic               block_o,
   output logic [SYND_W-1:0]  synd_o,
   output logic [ADDR_W-1:0]  addr_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bmask_o <= '0;
         dwoff_o <= '0;
         block_o <= 1'b0;
         addr_o  <= '0;
      end else if (load_i) begin
         bmask_o <= bmask_i;
         dwoff_o <= dwoff_i;
         block_o <= block_i;
         addr_o  <= addr_i;
      end
   end

   if (SYND_EN) begin : g_synd
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     synd_o <= '0;
         else if (load_i) synd_o <= synd_i;
      end
   end else begin : g_no_synd
      logic unused_synd;
      assign unused_synd = ^synd_i;
      assign synd_o = '0;
   end

   assert_hold_without_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> ($stable(addr_o) && $stable(bmask_o) && $stable(dwoff_o) && $stable(block_o)));

endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
   import errcap_pkg::*;
#(
   parameter int ADDR_W      = 34,
   parameter bit CORRECTABLE = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               evt_valid_i,
   input  logic [1:0]         evt_kind_i,
   input  logic [15:0]        evt_bmask_i,
   input  logic [2:0]         evt_dwoff_i,
   input  logic               evt_block_i,
   input  logic [7:0]         evt_synd_i,
   input  logic [ADDR_W-1:0]  evt_addr_i,
   input  logic               reg_sel_i,
   input  logic               reg_wr_i,
   input  logic [63:0]        reg_wdata_i,
   output logic [63:0]        reg_rdata_o,
   input  logic               irq_en_i,
   output logic               irq_o
);

   localparam logic [KINDS-1:0] KIND_EN = CORRECTABLE ? 3'b011 : 3'b111;

   if (ADDR_W < 6 || ADDR_W > STAT_W) begin : g_bad_addr_w
      $error("dma_err_capture: ADDR_W must lie in 6..64");
   end
   if (BMASK_W != 16 || DWOFF_W != 3 || SYND_W != 8) begin : g_bad_fields
      $error("dma_err_capture: status field widths do not fit the word layout");
   end

   logic [KINDS-1:0]   ev_set, clr_prim, clr_sec, prim_q, sec_q;
   logic               capture;
   logic               stat_wr;
   logic [BMASK_W-1:0] bmask_q;
   logic [DWOFF_W-1:0] dwoff_q;
   logic               block_q;
   logic [SYND_W-1:0]  synd_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [STAT_W-1:0]  status;
   logic               unused_wdata;

   assign ev_set  = evt_valid_i ? (kind_onehot(evt_kind_i) & KIND_EN) : '0;
   assign stat_wr = reg_wr_i & ~reg_sel_i;

   always_comb begin
      clr_prim = '0;
      clr_sec  = '0;
      for (int i = 0; i < KINDS; i++) begin
         clr_prim[i] = stat_wr & reg_wdata_i[PRIM_POS[i]];
         clr_sec[i]  = stat_wr & reg_wdata_i[SEC_POS[i]];
      end
   end
   assign unused_wdata = ^reg_wdata_i;

   errcap_flags #(.N(KINDS)) flags_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ev_set_i   (ev_set),
      .clr_prim_i (clr_prim),
      .clr_sec_i  (clr_sec),
      .prim_o     (prim_q),
      .sec_o      (sec_q),
      .capture_o  (capture)
   );

   errcap_detail #(.ADDR_W(ADDR_W), .SYND_EN(CORRECTABLE)) detail_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (capture),
      .bmask_i (evt_bmask_i),
      .dwoff_i (evt_dwoff_i),
      .block_i (evt_block_i),
      .synd_i  (evt_synd_i),
      .addr_i  (evt_addr_i),
      .bmask_o (bmask_q),
      .dwoff_o (dwoff_q),
      .block_o (block_q),
      .synd_o  (synd_q),
      .addr_o  (addr_q)
   );

   always_comb begin
      status = '0;
      for (int i = 0; i < KINDS; i++) begin
         if (KIND_EN[i]) begin
            status[PRIM_POS[i]] = prim_q[i];
            status[SEC_POS[i]]  = sec_q[i];
         end
      end
      status[BMASK_LO +: BMASK_W] = bmask_q;
      status[SYND_LO  +: SYND_W]  = synd_q;
      status[DWOFF_LO +: DWOFF_W] = dwoff_q;
      status[BLOCK_POS]           = block_q;
   end

   assign reg_rdata_o = reg_sel_i ? STAT_W'(addr_q) : status;
   assign irq_o       = irq_en_i & (|prim_q);

   assert_details_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|prim_q) && !stat_wr) |=> ($stable(addr_q) && $stable(bmask_q) && $stable(synd_q)));
   assert_irq_follows_event_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|ev_set) && irq_en_i) |=> (irq_o || !irq_en_i));

   if (CORRECTABLE) begin : g_ce_checks
      assert_xlate_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (evt_valid_i && evt_kind_i == ERR_XL && !stat_wr) |=> ($stable(prim_q) && $stable(sec_q)));
   end

endmodule

// File: tb/dma_err_capture_tb_top.sv
`timescale 1ns/1ps
module dma_err_capture_tb_top;

   localparam int AW = 34;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt_valid = 1'b0;
   logic [1:0]    evt_kind = '0;
   logic [15:0]   evt_bmask = '0;
   logic [2:0]    evt_dwoff = '0;
   logic          evt_block = 1'b0;
   logic [7:0]    evt_synd = '0;
   logic [AW-1:0] evt_addr = '0;
   logic          reg_sel = 1'b0;
   logic          reg_wr = 1'b0;
   logic [63:0]   reg_wdata = '0;
   logic          irq_en = 1'b0;
   logic [63:0]   rdata_m, rdata_c;
   logic          irq_m, irq_c;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dma_err_capture #(.ADDR_W(AW), .CORRECTABLE(1'b0)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(evt_valid), .evt_kind_i(evt_kind),
      .evt_bmask_i(evt_bmask), .evt_dwoff_i(evt_dwoff), .evt_block_i(evt_block),
      .evt_synd_i(evt_synd), .evt_addr_i(evt_addr), .reg_sel_i(reg_sel),
      .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata_m),
      .irq_en_i(irq_en), .irq_o(irq_m));

   dma_err_capture #(.ADDR_W(AW), .CORRECTABLE(1'b1)) dut_ce_i (
      .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(evt_valid), .evt_kind_i(evt_kind),
      .evt_bmask_i(evt_bmask), .evt_dwoff_i(evt_dwoff), .evt_block_i(evt_block),
      .evt_synd_i(evt_synd), .evt_addr_i(evt_addr), .reg_sel_i(reg_sel),
      .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata_c),
      .irq_en_i(irq_en), .irq_o(irq_c));

   // status encoding; p/s index 0 read, 1 write, 2 translation
   function automatic logic [63:0] st(input logic [2:0] p, input logic [2:0] s,
                                      input logic [15:0] bm, input logic [2:0] off,
                                      input logic blk, input logic [7:0] syn);
      logic [63:0] r;
      r = '0;
      r[62] = p[0]; r[61] = p[1]; r[56] = p[2];
      r[59] = s[0]; r[58] = s[1]; r[57] = s[2];
      r[47:32] = bm; r[55:48] = syn; r[31:29] = off; r[23] = blk;
      return r;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // both instances are read at once; called at a negedge
   task automatic read_both(input logic sel, output logic [63:0] m, output logic [63:0] c);
      reg_sel = sel;
      #1;
      m = rdata_m;
      c = rdata_c;
   endtask

   task automatic expect_state(input string req, input logic [63:0] sm, input logic [63:0] sc,
                               input logic [63:0] am, input logic [63:0] ac,
                               input logic im, input logic ic);
      logic [63:0] m, c;
      read_both(1'b0, m, c);
      chk({req, " status"}, m, sm);
      chk({req, " status ce"}, c, sc);
      read_both(1'b1, m, c);
      chk({req, " address"}, m, am);
      chk({req, " address ce"}, c, ac);
      chk({req, " irq"}, {63'd0, irq_m}, {63'd0, im});
      chk({req, " irq ce"}, {63'd0, irq_c}, {63'd0, ic});
      reg_sel = 1'b0;
   endtask

   task automatic cycle(input logic ev, input logic [1:0] k, input logic [15:0] bm,
                        input logic [2:0] off, input logic blk, input logic [7:0] syn,
                        input logic [AW-1:0] a, input logic wr, input logic sel,
                        input logic [63:0] wd);
      @(negedge clk);
      evt_valid = ev; evt_kind = k; evt_bmask = bm; evt_dwoff = off;
      evt_block = blk; evt_synd = syn; evt_addr = a;
      reg_wr = wr; reg_sel = sel; reg_wdata = wd;
      @(negedge clk);
      evt_valid = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
   endtask

   localparam logic [AW-1:0] A1 = 34'h2_1234_5678;
   localparam logic [AW-1:0] A2 = 34'h0_0000_1000;
   localparam logic [AW-1:0] A3 = 34'h3_0000_0040;
   localparam logic [AW-1:0] A4 = 34'h1_ABCD_EF08;

   task automatic t_reset;
      expect_state("R1 reset", '0, '0, '0, '0, 1'b0, 1'b0);
   endtask

   task automatic t_first_capture;
      irq_en = 1'b1;
      cycle(1'b1, 2'd0, 16'h00F0, 3'd5, 1'b1, 8'hA5, A1, 1'b0, 1'b0, '0);
      expect_state("R2 R7 R8 first read error",
                   st(3'b001, 3'b000, 16'h00F0, 3'd5, 1'b1, 8'h00),
                   st(3'b001, 3'b000, 16'h00F0, 3'd5, 1'b1, 8'hA5),
                   64'(A1), 64'(A1), 1'b1, 1'b1);
   endtask

   task automatic t_secondary;
      cycle(1'b1, 2'd1, 16'hFFFF, 3'd1, 1'b0, 8'h3C, A2, 1'b0, 1'b0, '0);
      expect_state("R3 later write error",
                   st(3'b001, 3'b010, 16'h00F0, 3'd5, 1'b1, 8'h00),
                   st(3'b001, 3'b010, 16'h00F0, 3'd5, 1'b1, 8'hA5),
                   64'(A1), 64'(A1), 1'b1, 1'b1);
   endtask

   task automatic t_irq_gate;
      @(negedge clk);
      irq_en = 1'b0;
      #1;
      chk("R5 irq masked", {62'd0, irq_m, irq_c}, 64'd0);
      irq_en = 1'b1;
      #1;
      chk("R5 irq unmasked", {62'd0, irq_m, irq_c}, 64'd3);
   endtask

   task automatic t_w1c;
      // zero write changes nothing
      cycle(1'b0, 2'd0, '0, '0, 1'b0, '0, '0, 1'b1, 1'b0, 64'd0);
      expect_state("R4 zero write",
                   st(3'b001, 3'b010, 16'h00F0, 3'd5, 1'b1, 8'h00),
                   st(3'b001, 3'b010, 16'h00F0, 3'd5, 1'b1, 8'hA5),
                   64'(A1), 64'(A1), 1'b1, 1'b1);
      // clear write secondary; ones into detail fields have no effect
      cycle(1'b0, 2'd0, '0, '0, 1'b0, '0, '0, 1'b1, 1'b0,
            64'h00FF_FFFF_E080_0000 | (64'd1 << 58));
      expect_state("R4 clear secondary, details read-only",
                   st(3'b001, 3'b000, 16'h00F0, 3'd5, 1'b1, 8'h00),
                   st(3'b001, 3'b000, 16'h00F0, 3'd5, 1'b1, 8'hA5),
                   64'(A1), 64'(A1), 1'b1, 1'b1);
      // address register write is ignored
      cycle(1'b0, 2'd0, '0, '0, 1'b0, '0, '0, 1'b1, 1'b1, '1);
      expect_state("R4 address write ignored",
                   st(3'b001, 3'b000, 16'h00F0, 3'd5, 1'b1, 8'h00),
                   st(3'b001, 3'b000, 16'h00F0, 3'd5, 1'b1, 8'hA5),
                   64'(A1), 64'(A1), 1'b1, 1'b1);
   endtask

   task automatic t_clear_primary;
      cycle(1'b0, 2'd0, '0, '0, 1'b0, '0, '0, 1'b1, 1'b0, 64'd1 << 62);
      expect_state("R9 R5 primary cleared, details kept",
                   st(3'b000, 3'b000, 16'h00F0, 3'd5, 1'b1, 8'h00),
                   st(3'b000, 3'b000, 16'h00F0, 3'd5, 1'b1, 8'hA5),
                   64'(A1), 64'(A1), 1'b0, 1'b0);
   endtask

   task automatic t_new_capture;
      cycle(1'b1, 2'd1, 16'h0F0F, 3'd2, 1'b0, 8'h5A, A3, 1'b0, 1'b0, '0);
      expect_state("R2 recapture after clear",
                   st(3'b010, 3'b000, 16'h0F0F, 3'd2, 1'b0, 8'h00),
                   st(3'b010, 3'b000, 16'h0F0F, 3'd2, 1'b0, 8'h5A),
                   64'(A3), 64'(A3), 1'b1, 1'b1);
   endtask

   task automatic t_race;
      // translation event with a clear of the write primary in the same cycle
      cycle(1'b1, 2'd2, 16'h8001, 3'd7, 1'b1, 8'hFF, A4, 1'b1, 1'b0, 64'd1 << 61);
      expect_state("R6 R7 event wins over clear",
                   st(3'b100, 3'b000, 16'h8001, 3'd7, 1'b1, 8'h00),
                   st(3'b000, 3'b000, 16'h0F0F, 3'd2, 1'b0, 8'h5A),
                   64'(A4), 64'(A3), 1'b1, 1'b0);
   endtask

   task automatic t_xlate_secondary;
      cycle(1'b1, 2'd2, 16'h0001, 3'd0, 1'b0, 8'h11, A2, 1'b0, 1'b0, '0);
      expect_state("R3 R7 later translation error",
                   st(3'b100, 3'b100, 16'h8001, 3'd7, 1'b1, 8'h00),
                   st(3'b000, 3'b000, 16'h0F0F, 3'd2, 1'b0, 8'h5A),
                   64'(A4), 64'(A3), 1'b1, 1'b0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_capture();
      t_secondary();
      t_irq_gate();
      t_w1c();
      t_clear_primary();
      t_new_capture();
      t_race();
      t_xlate_secondary();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual hung expected finished");
      finish_run();
   end

endmodule